// File: doc/BRIEF.md
# Codec Clock and Sample-Rate Generator

This block sits beside a dual-channel voice codec's serial port and makes all of its timing from one master clock. It gives a one-cycle bit-clock enable, a one-cycle frame-sync pulse that fires on every 256th bit-clock enable, and one sample strobe per channel. The bit-clock divisor comes from a 3-bit rate-select code. Codes 0 to 3 pick fixed divisors. Codes 4 to 7 pick a bit clock at half the master clock.

Each channel's sample strobe is derived from a base tick that occurs once every 512 master-clock cycles. The tick is divided by a ratio W + N/D, where W (whole), N (numerator) and D (denominator) are 4-bit fields held per channel. A small accumulator spreads one extra base tick over the samples, so the average sample period is exactly 512·(W + N/D) master cycles.

Configuration arrives on plain input ports. It is captured only on a frame-sync cycle, so every change starts on a frame boundary. All outputs are enables in the master-clock domain.

Top module: `codec_rate_gen`

## Requirements
- R1: While reset is active, every output is low. After reset the block runs with rate-select code 0 and both channels at W=6, N=0, D=6, whatever the inputs hold, until the first frame sync: `bclk_en` repeats every 12 cycles, and the first `fsync` comes 255·12 cycles after the first `bclk_en`.
- R2: Rate-select codes 0, 1, 2 and 3 make `bclk_en` a one-cycle pulse every 12, 16, 6 and 8 master cycles respectively.
- R3: Rate-select codes 4, 5, 6 and 7 make `bclk_en` pulse every 2 master cycles.
- R4: `fsync` is a one-cycle pulse that repeats every 256 `bclk_en` pulses and always coincides with a `bclk_en` pulse.
- R5: The interval between two strobes on `smp_stb[c]` (bit 0 is channel 0, bit 1 is channel 1) is always a multiple of 512 master cycles. A frame sync always falls on the last cycle of a 512-cycle base period.
- R6: When N is nonzero, D is nonzero and N < D, each strobe interval is W or W+1 base ticks. Any D consecutive intervals total exactly W·D + N ticks. The first interval after a channel restart has no extra tick.
- R7: When N = 0, D = 0 or N ≥ D, every strobe interval of that channel is exactly W base ticks (W·512 master cycles).
- R8: A whole-part field W of 0 behaves as W = 1, so the strobe repeats every 512 master cycles and never stops.
- R9: Changes to the inputs take effect only on a cycle where `fsync` is high. Between frame syncs, the `bclk_en` spacing stays at the value set by the previously captured code.
- R10: When a channel's W, N or D differs from its captured value at a frame sync, that channel restarts. Its first strobe comes exactly 512·(W−1) + 2 cycles after the `fsync` cycle (with W = 0 treated as 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Rate-select code, captured at frame sync |
| ch0_whole | input | 4 | Channel 0 whole part W |
| ch0_num | input | 4 | Channel 0 fraction numerator N |
| ch0_den | input | 4 | Channel 0 fraction denominator D |
| ch1_whole | input | 4 | Channel 1 whole part W |
| ch1_num | input | 4 | Channel 1 fraction numerator N |
| ch1_den | input | 4 | Channel 1 fraction denominator D |
| bclk_en | output | 1 | Bit-clock enable pulse |
| fsync | output | 1 | Frame-sync pulse |
| smp_stb | output | 2 | Per-channel sample strobe, bit c for channel c |

## Verification
The bench first holds a non-default rate code and a new channel setting during reset. This shows the defaults govern the first frame. A design that captured inputs at any time would show the wrong bit-clock spacing before the first frame sync.

It then switches the rate code mid-frame. The old spacing must hold until the boundary and the new spacing must start exactly one divisor after it. A design that captured too early, or that failed to realign its counters, would move the pulses by a few cycles.

Fractional channels are checked in two ways. Every interval must be W or W+1 ticks, and every window of D intervals must sum to W·D + N. An accumulator that compared off by one, or failed to subtract D, would break the sum.

The remaining cases are W = 0, D = 0 and N ≥ D. A design that mishandled them would stall, drift, or insert extra ticks.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  localparam int FLD_W  = 4;
  localparam int MODE_W = 3;
  localparam int DIV_W  = 5;
  localparam int BASE_W = 9;
  localparam int BITS_W = 8;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [FLD_W-1:0] whole;
    logic [FLD_W-1:0] num;
    logic [FLD_W-1:0] den;
  } ch_cfg_t;

  localparam ch_cfg_t CH_CFG_RST = '{whole: 4'd6, num: 4'd0, den: 4'd6};
  localparam logic [MODE_W-1:0] MODE_RST = '0;

  // Bit-clock divisor per rate-select code; unlisted codes run at half rate.
  function automatic logic [DIV_W-1:0] bclk_div(input logic [MODE_W-1:0] code);
    logic [DIV_W-1:0] div;
    case (code)
      3'd0:    div = 5'd12;
      3'd1:    div = 5'd16;
      3'd2:    div = 5'd6;
      3'd3:    div = 5'd8;
      default: div = 5'd2;
    endcase
    return div;
  endfunction

endpackage

// File: rtl/ccg_rst_sync.sv
module ccg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ccg_base_tick.sv
module ccg_base_tick #(
  parameter int W = 9
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick,
  output logic last
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = (cnt_q == '0);
  assign last = &cnt_q;

  AST_TICK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_ni)
    last |=> tick); // R5

endmodule

// File: rtl/ccg_bit_frame.sv
module ccg_bit_frame #(
  parameter int DIV_W  = 5,
  parameter int BITS_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div,
  output logic             bclk_en,
  output logic             fsync
);

  logic [DIV_W-1:0]  div_cnt_q;
  logic [DIV_W-1:0]  div_cnt_d;
  logic [BITS_W-1:0] bit_cnt_q;
  logic [BITS_W-1:0] bit_cnt_d;
  logic [DIV_W-1:0]  div_last;

  assign div_last = div - DIV_W'(1);
  assign bclk_en  = (div_cnt_q >= div_last);
  assign fsync    = bclk_en & (&bit_cnt_q);

  always_comb begin
    if (bclk_en) begin
      div_cnt_d = '0;
    end else begin
      div_cnt_d = div_cnt_q + DIV_W'(1);
    end
    bit_cnt_d = bit_cnt_q + BITS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
    end else begin
      div_cnt_q <= div_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
    end else if (bclk_en) begin
      bit_cnt_q <= bit_cnt_d;
    end
  end

  AST_BCLK_GAP: assert property (@(posedge clk) disable iff (!rst_ni)
    bclk_en |=> !bclk_en); // R2
  AST_FSYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_ni)
    fsync |=> !fsync); // R4

endmodule

// File: rtl/ccg_frac_div.sv
module ccg_frac_div #(
  parameter int FLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             restart,
  input  logic [FLD_W-1:0] whole,
  input  logic [FLD_W-1:0] num,
  input  logic [FLD_W-1:0] den,
  output logic             stb
);

  localparam int CW = FLD_W + 1;

  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    cnt_d;
  logic [FLD_W-1:0] acc_q;
  logic [FLD_W-1:0] acc_d;
  logic             extra_q;
  logic             extra_d;
  logic             stb_q;
  logic             stb_d;

  logic [FLD_W-1:0] whole_eff;
  logic             frac_on;
  logic [CW-1:0]    target;
  logic [CW-1:0]    cnt_inc;
  logic [CW-1:0]    sum;
  logic             upd_en;

  assign whole_eff = (whole == '0) ? FLD_W'(1) : whole;
  assign frac_on   = (num != '0) && (den != '0) && (num < den);
  assign target    = {1'b0, whole_eff} + CW'(extra_q);
  assign cnt_inc   = cnt_q + CW'(1);
  assign sum       = {1'b0, acc_q} + {1'b0, num};
  assign upd_en    = restart | tick;

  always_comb begin
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    extra_d = extra_q;
    stb_d   = 1'b0;
    if (restart) begin
      cnt_d   = '0;
      acc_d   = '0;
      extra_d = 1'b0;
    end else if (tick) begin
      if (cnt_inc == target) begin
        stb_d = 1'b1;
        cnt_d = '0;
        if (frac_on) begin
          if (sum >= {1'b0, den}) begin
            acc_d   = FLD_W'(sum - {1'b0, den});
            extra_d = 1'b1;
          end else begin
            acc_d   = FLD_W'(sum);
            extra_d = 1'b0;
          end
        end else begin
          acc_d   = '0;
          extra_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      extra_q <= extra_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
    end
  end

  assign stb = stb_q;

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_ni)
    frac_on |-> (acc_q < den)); // R6
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q < target); // R8
  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    stb_q |-> $past(tick)); // R5

endmodule

// File: rtl/codec_rate_gen.sv
module codec_rate_gen
  import ccg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [FLD_W-1:0]  ch0_whole,
  input  logic [FLD_W-1:0]  ch0_num,
  input  logic [FLD_W-1:0]  ch0_den,
  input  logic [FLD_W-1:0]  ch1_whole,
  input  logic [FLD_W-1:0]  ch1_num,
  input  logic [FLD_W-1:0]  ch1_den,
  output logic              bclk_en,
  output logic              fsync,
  output logic [NUM_CH-1:0] smp_stb
);

  logic              rst_ni;
  logic [MODE_W-1:0] mode_q;
  ch_cfg_t           cfg_q  [NUM_CH];
  ch_cfg_t           cfg_in [NUM_CH];
  logic [DIV_W-1:0]  div;
  logic              base_tick;
  logic              base_last;
  logic [NUM_CH-1:0] restart;

  assign cfg_in[0] = '{whole: ch0_whole, num: ch0_num, den: ch0_den};
  assign cfg_in[1] = '{whole: ch1_whole, num: ch1_num, den: ch1_den};

  ccg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  ccg_base_tick #(.W(BASE_W)) i_base_tick (
    .clk    (clk),
    .rst_ni (rst_ni),
    .tick   (base_tick),
    .last   (base_last)
  );

  assign div = bclk_div(mode_q);

  ccg_bit_frame #(.DIV_W(DIV_W), .BITS_W(BITS_W)) i_bit_frame (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .div     (div),
    .bclk_en (bclk_en),
    .fsync   (fsync)
  );

  // Configuration capture, enabled on frame sync only.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      for (int c = 0; c < NUM_CH; c++) begin
        cfg_q[c] <= CH_CFG_RST;
      end
    end else if (fsync) begin
      mode_q <= mode_sel;
      for (int c = 0; c < NUM_CH; c++) begin
        cfg_q[c] <= cfg_in[c];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign restart[c] = fsync && (cfg_in[c] != cfg_q[c]);

    ccg_frac_div #(.FLD_W(FLD_W)) i_frac_div (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .tick    (base_tick),
      .restart (restart[c]),
      .whole   (cfg_q[c].whole),
      .num     (cfg_q[c].num),
      .den     (cfg_q[c].den),
      .stb     (smp_stb[c])
    );
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !fsync |=> $stable(mode_q)); // R9
  AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_ni)
    fsync |-> base_last); // R5

endmodule

// File: tb/test_codec_rate_gen.sv
module test_codec_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_sel;
  logic [3:0] c0w, c0n, c0d, c1w, c1n, c1d;
  logic       bclk_en, fsync;
  logic [1:0] smp_stb;

  longint cyc = 0;
  int total = 0;
  int bad = 0;

  int sh_mode;
  int sh_w [2];
  int sh_n [2];
  int sh_d [2];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  codec_rate_gen i_codec_rate_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .ch0_whole (c0w),
    .ch0_num   (c0n),
    .ch0_den   (c0d),
    .ch1_whole (c1w),
    .ch1_num   (c1n),
    .ch1_den   (c1d),
    .bclk_en   (bclk_en),
    .fsync     (fsync),
    .smp_stb   (smp_stb)
  );

  function automatic int div_of(int m);
    case (m)
      0: return 12;
      1: return 16;
      2: return 6;
      3: return 8;
      default: return 2;
    endcase
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bclk(output longint t);
    do @(negedge clk); while (!bclk_en);
    t = cyc;
  endtask

  task automatic wait_fsync(output longint t);
    while (!fsync) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_stb(int ch, output longint t);
    do @(negedge clk); while (!smp_stb[ch]);
    t = cyc;
  endtask

  task automatic chan_check(int ch, longint tf, int w, int n, int d, bit changed);
    int ie;
    bit frac;
    int cnt;
    longint t0, t, prev, iv, sum;
    ie   = (w == 0) ? 1 : w;
    frac = (n != 0) && (d != 0) && (n < d);
    wait_stb(ch, t0);
    if (changed) chk((w == 0) ? "R8 first strobe" : "R10 first strobe", t0 - tf, 512 * (ie - 1) + 2);
    cnt  = frac ? d : 3;
    sum  = 0;
    prev = t0;
    for (int k = 0; k < cnt; k++) begin
      wait_stb(ch, t);
      iv   = t - prev;
      prev = t;
      sum += iv;
      if (frac) begin
        if (k == 0 && changed) chk("R6 first interval", iv, 512 * ie);
        chk("R5 interval in range",
            ((iv == 512 * ie) || (iv == 512 * (ie + 1))) ? 1 : 0, 1);
      end else begin
        chk((w == 0) ? "R8 interval" : "R7 interval", iv, 512 * ie);
      end
    end
    if (frac) chk("R6 window sum", sum, 512 * (ie * d + n));
  endtask

  task automatic frame_check(longint tf, int m);
    longint t1, t2;
    wait_bclk(t1);
    chk((m >= 4) ? "R3 bclk spacing" : "R2 bclk spacing", t1 - tf, div_of(m));
    wait_bclk(t2);
    chk((m >= 4) ? "R3 bclk spacing" : "R2 bclk spacing", t2 - t1, div_of(m));
    @(negedge clk);
    wait_fsync(t2);
    chk("R4 frame period", t2 - tf, 256 * div_of(m));
    chk("R4 fsync on bclk", bclk_en, 1);
  endtask

  task automatic drive(int m, int w0, int n0, int d0, int w1, int n1, int d1);
    mode_sel = 3'(m);
    c0w = 4'(w0); c0n = 4'(n0); c0d = 4'(d0);
    c1w = 4'(w1); c1n = 4'(n1); c1d = 4'(d1);
  endtask

  task automatic verify(longint tf, int m, int w0, int n0, int d0, int w1, int n1, int d1,
                        bit ch0_new, bit ch1_new);
    fork
      frame_check(tf, m);
      chan_check(0, tf, w0, n0, d0, ch0_new);
      chan_check(1, tf, w1, n1, d1, ch1_new);
    join
  endtask

  task automatic trial(int m, int w0, int n0, int d0, int w1, int n1, int d1);
    longint tf;
    bit ch0_new, ch1_new;
    drive(m, w0, n0, d0, w1, n1, d1);
    ch0_new = (w0 != sh_w[0]) || (n0 != sh_n[0]) || (d0 != sh_d[0]);
    ch1_new = (w1 != sh_w[1]) || (n1 != sh_n[1]) || (d1 != sh_d[1]);
    wait_fsync(tf);
    sh_mode = m;
    sh_w[0] = w0; sh_n[0] = n0; sh_d[0] = d0;
    sh_w[1] = w1; sh_n[1] = n1; sh_d[1] = d1;
    verify(tf, m, w0, n0, d0, w1, n1, d1, ch0_new, ch1_new);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint t1, t2, tf;
    int m;
    void'($urandom(32'd20240611));
    sh_mode = 0;
    for (int c = 0; c < 2; c++) begin
      sh_w[c] = 6; sh_n[c] = 0; sh_d[c] = 6;
    end
    rst_n = 1'b0;
    // Non-default inputs during reset: must not act before the first frame sync.
    drive(3, 6, 0, 6, 1, 0, 0);
    repeat (4) @(negedge clk);
    chk("R1 reset bclk_en", bclk_en, 0);
    chk("R1 reset fsync", fsync, 0);
    chk("R1 reset smp_stb", smp_stb, 0);
    rst_n = 1'b1;

    wait_bclk(t1);
    wait_bclk(t2);
    chk("R1 default bclk spacing", t2 - t1, 12);
    wait_fsync(tf);
    chk("R1 default first frame", tf - t1, 255 * 12);
    sh_mode = 3;
    sh_w[1] = 1; sh_n[1] = 0; sh_d[1] = 0;
    verify(tf, 3, 6, 0, 6, 1, 0, 0, 1'b0, 1'b1);

    // Directed corner cases.
    trial(4, 0, 0, 0, 0, 3, 5);   // R8 zero whole part, R6 with W treated as 1
    trial(2, 3, 5, 3, 2, 3, 0);   // R7 N >= D and D = 0
    trial(7, 2, 3, 4, 1, 1, 2);   // R6 fractional ratios

    // R9: change the rate code right after a frame boundary.
    @(negedge clk);
    wait_fsync(tf);
    @(negedge clk);
    m = 1;
    mode_sel = 3'(m);
    wait_bclk(t1);
    wait_bclk(t2);
    chk("R9 old spacing held", t2 - t1, div_of(sh_mode));
    wait_fsync(tf);
    wait_bclk(t1);
    chk("R9 new spacing after fsync", t1 - tf, div_of(m));
    sh_mode = m;

    // Constrained random configurations.
    for (int k = 0; k < 5; k++) begin
      trial(int'($urandom_range(7, 0)),
            int'($urandom_range(2, 0)), int'($urandom_range(7, 0)), int'($urandom_range(7, 0)),
            int'($urandom_range(2, 0)), int'($urandom_range(7, 0)), int'($urandom_range(7, 0)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule